// File: doc/BRIEF.md
# Base-Limit Memory Protection Unit

This block checks every access address against a small table of protection regions. A region is a contiguous address range. Its start is given by a base address and its end by an inclusive limit address. Both are kept only down to an alignment granule. For each access the unit reports one of three results. If exactly one enabled region covers the address, it reports a hit. If several enabled regions cover it, it reports an overlap. Otherwise it reports a miss. On a hit it also gives the matched region's number, its permission and shareability fields, its execute-never flag, and an 8-bit memory attribute. That attribute is fetched indirectly through the region's 3-bit index into eight packed attribute bytes. It also returns a single allow decision for the requested access type and privilege.

Software programs the table through a small byte-addressed register window. A region-select register picks the region that the primary base and limit registers reach. Further alias pairs reach the region at select plus a fixed step. This lets several neighbouring regions be written without rewriting the select register. Matching is purely combinational, and register writes take effect at the next clock edge.

Top module: `bl_mpu`

## Requirements
- R1: After reset every register reads zero and no access address hits any region.
- R2: A region matches address A when A, with its low GRAN_LOG2 bits dropped, lies between the base and the limit taken the same way, both ends included. So the limit covers the whole of its final granule (default granule 32 bytes).
- R3: Bit 0 of a limit register enables its region. A region whose enable bit is 0 never matches, and it does not count toward an overlap.
- R4: The attribute register at offset 0xC0 holds entries 0–3 and the one at 0xC4 holds entries 4–7. Entry n sits at bits [8·(n mod 4)+7 : 8·(n mod 4)]. On a hit, accAttr is the entry selected by limit bits [3:1].
- R5: In a base register, bit 0 is execute-never, bits [2:1] are the permission code and bits [4:3] are shareability. On a hit these are reported as accXn, accAp and accSh.
- R6: The select register at 0x98 reads back the value written to its low 8 bits. Writes and reads at 0x9C (base) and 0xA0 (limit) reach the region it names.
- R7: For step k = 1..NUM_ALIAS, offsets 0x9C+8·k and 0xA0+8·k reach the base and limit of region select+k.
- R8: When the selected region number (select+k) is at or above NUM_RGN, writes change no region and reads return zero.
- R9: An address covered by two or more enabled regions gives accOverlap=1, accHit=0, and zero region number, fields and attribute.
- R10: On a miss, accHit, accRegion, accAp, accSh, accXn, accAttr and accAllow are all zero.
- R11: accAllow is 1 only on a hit whose permission code allows the access. Code 00 allows privileged read/write only. Code 01 allows read/write at both levels. Code 11 allows reads only at both levels. Code 10 allows nothing. An instruction fetch counts as a read, and a fetch is refused when execute-never is set.
- R12: A limit register reads back with bits [GRAN_LOG2-1:4] zero. A base register reads back with bits [GRAN_LOG2-1:5] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte offset into the register window |
| regWrEn | input | 1 | Write strobe for the register window |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| accAddr | input | 32 | Address of the access being checked |
| accWrite | input | 1 | Access is a write |
| accFetch | input | 1 | Access is an instruction fetch |
| accPriv | input | 1 | Access is made at the privileged level |
| accHit | output | 1 | Exactly one enabled region covers accAddr |
| accOverlap | output | 1 | More than one enabled region covers accAddr |
| accRegion | output | 4 | Number of the matched region |
| accAp | output | 2 | Permission code of the matched region |
| accSh | output | 2 | Shareability of the matched region |
| accXn | output | 1 | Execute-never of the matched region |
| accAttr | output | 8 | Memory attribute looked up for the matched region |
| accAllow | output | 1 | Access is permitted |

## Verification
The hardest case to reach from the ports is an alias write whose computed region number runs past the implemented count. Here the select value is itself legal and only the sum overflows. A decoder that wraps the index would quietly corrupt a low region instead. The stimulus sets the select register near the top of the table and writes through the largest alias step. It then reads the alias back. It also probes both the target address range and the ranges of the low regions that a wrapped index would land on. The overlap case is reached by programming two enabled regions that share part of their span. The test then drops one of them through its enable bit and checks that the other becomes a clean hit.

// File: rtl/bl_mpu_pkg.sv
package bl_mpu_pkg;
  localparam int MAX_RGN_W = 4;
  localparam int OFF_SEL   = 'h98;
  localparam int OFF_BASE  = 'h9C;
  localparam int OFF_LIMIT = 'hA0;
  localparam int OFF_ATTR0 = 'hC0;
  localparam int OFF_ATTR1 = 'hC4;
  localparam int ALIAS_STEP = 8;

  typedef enum logic [2:0] {
    RD_NONE, RD_SEL, RD_BASE, RD_LIMIT, RD_ATTR0, RD_ATTR1
  } rdKind_e;

  typedef struct packed {
    logic                 wrSel;
    logic                 wrBase;
    logic                 wrLimit;
    logic                 wrAttr0;
    logic                 wrAttr1;
    logic                 tgtOk;
    logic [MAX_RGN_W-1:0] tgtIdx;
    rdKind_e              rdKind;
  } ctrlStrb_t;
endpackage

// File: rtl/bl_mpu_ctrl.sv
module bl_mpu_ctrl
  import bl_mpu_pkg::*;
#(
  parameter int NUM_RGN   = 8,
  parameter int NUM_ALIAS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] selVal,
  output ctrlStrb_t  strb
);
  logic       isBase, isLimit;
  logic [8:0] slot;
  logic [8:0] tgtWide;
  logic       tgtOk;

  always_comb begin
    isBase = 1'b0;
    isLimit = 1'b0;
    slot = '0;
    for (int k = 0; k <= NUM_ALIAS; k++) begin
      if (regAddr == 8'(OFF_BASE + ALIAS_STEP * k)) begin
        isBase = 1'b1;
        slot = 9'(k);
      end
      if (regAddr == 8'(OFF_LIMIT + ALIAS_STEP * k)) begin
        isLimit = 1'b1;
        slot = 9'(k);
      end
    end
    tgtWide = {1'b0, selVal} + slot;
    tgtOk = (tgtWide < 9'(NUM_RGN));
  end

  always_comb begin
    strb = '0;
    strb.tgtOk  = tgtOk;
    strb.tgtIdx = tgtWide[MAX_RGN_W-1:0];
    strb.wrSel   = regWrEn && (regAddr == 8'(OFF_SEL));
    strb.wrBase  = regWrEn && isBase && tgtOk;
    strb.wrLimit = regWrEn && isLimit && tgtOk;
    strb.wrAttr0 = regWrEn && (regAddr == 8'(OFF_ATTR0));
    strb.wrAttr1 = regWrEn && (regAddr == 8'(OFF_ATTR1));
    if (regAddr == 8'(OFF_SEL))        strb.rdKind = RD_SEL;
    else if (isBase)                   strb.rdKind = RD_BASE;
    else if (isLimit)                  strb.rdKind = RD_LIMIT;
    else if (regAddr == 8'(OFF_ATTR0)) strb.rdKind = RD_ATTR0;
    else if (regAddr == 8'(OFF_ATTR1)) strb.rdKind = RD_ATTR1;
    else                               strb.rdKind = RD_NONE;
  end

  generate
    if (NUM_ALIAS >= 1) begin : gAliasChk
      // R7
      alias_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (regWrEn && regAddr == 8'hA4 && {1'b0, selVal} < 9'(NUM_RGN - 1))
          |-> (strb.wrBase && strb.tgtIdx == MAX_RGN_W'(selVal + 8'd1)));
    end
  endgenerate
endmodule

// File: rtl/bl_mpu_dpath.sv
module bl_mpu_dpath
  import bl_mpu_pkg::*;
#(
  parameter int NUM_RGN   = 8,
  parameter int GRAN_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [7:0]           selVal,
  input  logic [31:0]          accAddr,
  input  logic                 accWrite,
  input  logic                 accFetch,
  input  logic                 accPriv,
  output logic                 accHit,
  output logic                 accOverlap,
  output logic [MAX_RGN_W-1:0] accRegion,
  output logic [1:0]           accAp,
  output logic [1:0]           accSh,
  output logic                 accXn,
  output logic [7:0]           accAttr,
  output logic                 accAllow
);
  localparam int HI_W = 32 - GRAN_LOG2;

  logic [7:0]      selReg;
  logic [31:0]     attr0, attr1;
  logic [HI_W-1:0] baseHiA [NUM_RGN];
  logic [4:0]      baseFldA[NUM_RGN];
  logic [HI_W-1:0] limHiA  [NUM_RGN];
  logic            limEnA  [NUM_RGN];
  logic [2:0]      limIdxA [NUM_RGN];
  logic [NUM_RGN-1:0] match;
  logic [HI_W-1:0] accHi;
  logic            unusedBits;

  assign accHi = accAddr[31:GRAN_LOG2];
  assign unusedBits = ^{regWrData, accAddr[GRAN_LOG2-1:0]};
  assign selVal = selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      attr0  <= '0;
      attr1  <= '0;
    end else begin
      if (strb.wrSel)   selReg <= regWrData[7:0];
      if (strb.wrAttr0) attr0  <= regWrData;
      if (strb.wrAttr1) attr1  <= regWrData;
    end
  end

  for (genvar r = 0; r < NUM_RGN; r++) begin : gRgn
    logic [HI_W-1:0] baseHi, limHi;
    logic [4:0]      baseFld;
    logic            limEn;
    logic [2:0]      limIdx;
    logic            picked;

    assign picked = strb.tgtOk && (strb.tgtIdx == MAX_RGN_W'(r));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseHi  <= '0;
        baseFld <= '0;
        limHi   <= '0;
        limEn   <= 1'b0;
        limIdx  <= '0;
      end else begin
        if (strb.wrBase && picked) begin
          baseHi  <= regWrData[31:GRAN_LOG2];
          baseFld <= regWrData[4:0];
        end
        if (strb.wrLimit && picked) begin
          limHi  <= regWrData[31:GRAN_LOG2];
          limEn  <= regWrData[0];
          limIdx <= regWrData[3:1];
        end
      end
    end

    assign baseHiA[r]  = baseHi;
    assign baseFldA[r] = baseFld;
    assign limHiA[r]   = limHi;
    assign limEnA[r]   = limEn;
    assign limIdxA[r]  = limIdx;
    assign match[r] = limEn && (accHi >= baseHi) && (accHi <= limHi);
  end

  // register read path
  always_comb begin
    regRdData = '0;
    case (strb.rdKind)
      RD_SEL:   regRdData[7:0] = selReg;
      RD_ATTR0: regRdData = attr0;
      RD_ATTR1: regRdData = attr1;
      RD_BASE: begin
        for (int r = 0; r < NUM_RGN; r++) begin
          if (strb.tgtOk && strb.tgtIdx == MAX_RGN_W'(r)) begin
            regRdData[31:GRAN_LOG2] = baseHiA[r];
            regRdData[4:0] = baseFldA[r];
          end
        end
      end
      RD_LIMIT: begin
        for (int r = 0; r < NUM_RGN; r++) begin
          if (strb.tgtOk && strb.tgtIdx == MAX_RGN_W'(r)) begin
            regRdData[31:GRAN_LOG2] = limHiA[r];
            regRdData[3:0] = {limIdxA[r], limEnA[r]};
          end
        end
      end
      default: regRdData = '0;
    endcase
  end

  // match resolution and attribute lookup
  logic       multi;
  logic [4:0] hitFld;
  logic [2:0] hitIdx;
  logic [31:0] attrWord;
  logic       permOk;

  always_comb begin
    multi = (match & (match - 1'b1)) != '0;
    accHit = (match != '0) && !multi;
    accOverlap = multi;
    accRegion = '0;
    hitFld = '0;
    hitIdx = '0;
    if (accHit) begin
      for (int r = 0; r < NUM_RGN; r++) begin
        if (match[r]) begin
          accRegion = MAX_RGN_W'(r);
          hitFld = baseFldA[r];
          hitIdx = limIdxA[r];
        end
      end
    end
    accXn = hitFld[0];
    accAp = hitFld[2:1];
    accSh = hitFld[4:3];
    attrWord = hitIdx[2] ? attr1 : attr0;
    accAttr = accHit ? attrWord[8*hitIdx[1:0] +: 8] : 8'h00;
    case (accAp)
      2'b00:   permOk = accPriv;
      2'b01:   permOk = 1'b1;
      2'b11:   permOk = !accWrite;
      default: permOk = 1'b0;
    endcase
    accAllow = accHit && permOk && !(accFetch && accXn);
  end

  // R9
  overlap_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    accOverlap |-> !accHit);
  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accHit |-> (accAttr == 8'h00 && accAp == 2'b00 && accSh == 2'b00 &&
                 !accXn && accRegion == '0 && !accAllow));
  // R11
  fetch_xn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accAllow && accFetch) |-> !accXn);
  // R6
  sel_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSel |=> (selReg == $past(regWrData[7:0])));
  // R8
  oob_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rdKind == RD_BASE || strb.rdKind == RD_LIMIT) && !strb.tgtOk)
      |-> (regRdData == 32'h0));
endmodule

// File: rtl/bl_mpu.sv
module bl_mpu
  import bl_mpu_pkg::*;
#(
  parameter int NUM_RGN   = 8,
  parameter int GRAN_LOG2 = 5,
  parameter int NUM_ALIAS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [31:0] accAddr,
  input  logic        accWrite,
  input  logic        accFetch,
  input  logic        accPriv,
  output logic        accHit,
  output logic        accOverlap,
  output logic [3:0]  accRegion,
  output logic [1:0]  accAp,
  output logic [1:0]  accSh,
  output logic        accXn,
  output logic [7:0]  accAttr,
  output logic        accAllow
);
  ctrlStrb_t  strb;
  logic [7:0] selVal;

  bl_mpu_ctrl #(.NUM_RGN(NUM_RGN), .NUM_ALIAS(NUM_ALIAS)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .selVal(selVal), .strb(strb)
  );

  bl_mpu_dpath #(.NUM_RGN(NUM_RGN), .GRAN_LOG2(GRAN_LOG2)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .selVal(selVal), .accAddr(accAddr),
    .accWrite(accWrite), .accFetch(accFetch), .accPriv(accPriv),
    .accHit(accHit), .accOverlap(accOverlap), .accRegion(accRegion),
    .accAp(accAp), .accSh(accSh), .accXn(accXn), .accAttr(accAttr),
    .accAllow(accAllow)
  );
endmodule

// File: tb/bl_mpu_test.sv
`timescale 1ns/1ps
module bl_mpu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0, accFetch = 1'b0, accPriv = 1'b0;
  logic        accHit, accOverlap, accXn, accAllow;
  logic [3:0]  accRegion;
  logic [1:0]  accAp, accSh;
  logic [7:0]  accAttr;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bl_mpu uut (.*);

  function automatic logic [7:0] attrByte(input int n);
    return 8'(n * 37 + 11);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(tag, regRdData, exp);
  endtask

  // packs {hit, overlap, region, attr} for compact comparison
  task automatic acc(input string tag, input logic [31:0] a, input logic h,
                     input logic o, input logic [3:0] r, input logic [7:0] at);
    @(negedge clk);
    accAddr = a; accWrite = 1'b0; accFetch = 1'b0; accPriv = 1'b1;
    #1 chk(tag, {18'h0, accHit, accOverlap, accRegion, accAttr},
                {18'h0, h, o, r, at});
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd("R1 sel", 8'h98, 0);
    rd("R1 base", 8'h9C, 0);
    rd("R1 limit", 8'hA0, 0);
    rd("R1 attr0", 8'hC0, 0);
    rd("R1 attr1", 8'hC4, 0);
    acc("R1 nohit", 32'h0000_0000, 0, 0, 0, 0);
    acc("R1 nohit hi", 32'hFFFF_FFF0, 0, 0, 0, 0);

    // R4 attribute registers
    wr(8'hC0, {attrByte(3), attrByte(2), attrByte(1), attrByte(0)});
    wr(8'hC4, {attrByte(7), attrByte(6), attrByte(5), attrByte(4)});
    rd("R4 attr0 rb", 8'hC0, {attrByte(3), attrByte(2), attrByte(1), attrByte(0)});
    rd("R4 attr1 rb", 8'hC4, {attrByte(7), attrByte(6), attrByte(5), attrByte(4)});

    // region 0 via primary pair; R12 bit4 of limit reads zero
    wr(8'h98, 0);
    wr(8'h9C, 32'h0000_1005);
    wr(8'hA0, 32'h0000_1FFF);
    rd("R12 base rb", 8'h9C, 32'h0000_1005);
    rd("R12 limit rb", 8'hA0, 32'h0000_1FEF);
    // R2 boundaries, limit covers its whole granule
    acc("R2 below", 32'h0000_0FFF, 0, 0, 0, 0);
    acc("R2 base", 32'h0000_1000, 1, 0, 0, attrByte(7));
    acc("R2 mid", 32'h0000_1013, 1, 0, 0, attrByte(7));
    acc("R2 last", 32'h0000_1FFF, 1, 0, 0, attrByte(7));
    acc("R2 above", 32'h0000_2000, 0, 0, 0, 0);

    // R5 / R11 sweep over all field codes and access kinds
    for (int f = 0; f < 32; f++) begin
      wr(8'h9C, 32'h0000_1000 | f);
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 3; m++) begin
          logic expAllow;
          logic w, x;
          int ap;
          w = (m == 1);
          x = (m == 2);
          ap = (f >> 1) & 3;
          case (ap)
            0: expAllow = (p == 1);
            1: expAllow = 1'b1;
            3: expAllow = !w;
            default: expAllow = 1'b0;
          endcase
          if (x && (f & 1) != 0) expAllow = 1'b0;
          @(negedge clk);
          accAddr = 32'h0000_1400; accWrite = w; accFetch = x; accPriv = p[0];
          #1;
          if (p == 0 && m == 0)
            chk("R5 fields", {27'h0, accSh, accAp, accXn},
                {27'h0, 2'((f >> 3) & 3), 2'(ap), 1'(f & 1)});
          chk("R11 allow", {31'h0, accAllow}, {31'h0, expAllow});
        end
      end
    end
    wr(8'h9C, 32'h0000_1000);

    // R4 attribute index sweep
    for (int n = 0; n < 8; n++) begin
      wr(8'hA0, 32'h0000_1FE1 | (n << 1));
      acc("R4 idx", 32'h0000_1100, 1, 0, 0, attrByte(n));
    end

    // R9 overlap with region 1
    wr(8'h98, 1);
    wr(8'h9C, 32'h0000_1800);
    wr(8'hA0, 32'h0000_27E1);
    acc("R9 overlap", 32'h0000_1900, 0, 1, 0, 0);
    acc("R9 single r1", 32'h0000_2100, 1, 0, 1, attrByte(0));
    acc("R9 single r0", 32'h0000_1100, 1, 0, 0, attrByte(7));

    // R3 disable region 0
    wr(8'h98, 0);
    wr(8'hA0, 32'h0000_1FEE);
    acc("R3 disabled", 32'h0000_1100, 0, 0, 0, 0);
    acc("R3 no overlap", 32'h0000_1900, 1, 0, 1, attrByte(0));
    @(negedge clk);
    accAddr = 32'h0000_1100; accPriv = 1'b1;
    #1 chk("R10 miss fields", {26'h0, accSh, accAp, accXn, accAllow}, 32'h0);

    // R7 alias steps from select 2
    wr(8'h98, 2);
    wr(8'hA4, 32'h0000_4002);
    wr(8'hA8, 32'h0000_4FE1);
    wr(8'hB4, 32'h0000_6000);
    wr(8'hB8, 32'h0000_6FE1);
    acc("R7 alias k1", 32'h0000_4800, 1, 0, 3, attrByte(0));
    acc("R7 alias k3", 32'h0000_6010, 1, 0, 5, attrByte(0));
    rd("R7 alias rb", 8'hA4, 32'h0000_4002);
    wr(8'h98, 3);
    rd("R6 primary rb", 8'h9C, 32'h0000_4002);
    rd("R6 sel rb", 8'h98, 32'h3);

    // R8 out of range through alias and primary
    wr(8'h98, 6);
    wr(8'hB4, 32'h0000_8000);
    wr(8'hB8, 32'h0000_8FE1);
    rd("R8 alias rd", 8'hB4, 0);
    acc("R8 alias nohit", 32'h0000_8010, 0, 0, 0, 0);
    acc("R8 r1 intact", 32'h0000_2100, 1, 0, 1, attrByte(0));
    wr(8'h98, 9);
    wr(8'h9C, 32'h0000_A000);
    wr(8'hA0, 32'h0000_AFE1);
    rd("R8 primary rd", 8'h9C, 0);
    rd("R6 sel 9", 8'h98, 32'h9);
    acc("R8 primary nohit", 32'h0000_A010, 0, 0, 0, 0);
    acc("R8 r1 still", 32'h0000_2100, 1, 0, 1, attrByte(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule